// File: doc/BRIEF.md
# Asymmetric Partitioned Dual-Port RAM

This block is a synchronous RAM of 2048 bytes with two independent access ports that differ in width. The narrow port moves one byte per access and uses an 11-bit byte address. The wide port moves a 32-bit word per access and uses a 9-bit word address. Both ports see the same storage, so data written through one can be read through the other. Byte `k` of a wide word is the byte at narrow address `{word_address, k[1:0]}`, and byte 0 travels on bits 7:0.

Each port has its own enable, write strobe, address and data. Both ports may read or write in the same cycle. Accesses to different locations never disturb each other. If both ports write the same location in one cycle, the stored value is not defined. If one port reads a location in the cycle the other port writes it, the read data is not defined either. Users must avoid relying on either case.

A build-time partition option splits the array into two private halves. It forces one chosen byte-address bit to 0 on the narrow port and to 1 on the wide port. A typical use is a processor on the wide port and a byte-oriented engine on the narrow port, each with a scratch region the other cannot touch.

Top module: `asym_dpram`

## Requirements
- R1: During reset and on the first cycle after the internal reset releases, `n_rdata` and `w_rdata` are all zeros.
- R2: A narrow access with `n_en`=1 at clock edge t shows the addressed byte on `n_rdata` after edge t. A narrow write with `n_en`=1 and `n_we`=1 stores `n_wdata` at `n_addr`.
- R3: A wide access with `w_en`=1 at clock edge t shows the addressed word on `w_rdata` after edge t. A wide write stores `w_wdata` at `w_addr`.
- R4: Byte k (k = 0..3) of wide word W is the byte at narrow address W*4+k, and it sits on bits 8k+7:8k of the wide data.
- R5: A port that writes returns on its read output the contents the location held before that write (read-first).
- R6: While a port's enable is 0, its read output holds its previous value and the port writes nothing, whatever its write strobe, address and data are.
- R7: Writes from both ports in the same cycle to different words are both stored.
- R8: With `PART_EN`=1, narrow byte-address bit `PART_BIT` is forced to 0 and wide word-address bit `PART_BIT`-2 is forced to 1. Narrow addresses that differ only in that bit alias to each other. Writes from one port never appear in the other port's half.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| n_en | input | 1 | Narrow port access enable |
| n_we | input | 1 | Narrow port write strobe, acted on only with `n_en` |
| n_addr | input | 11 | Narrow port byte address |
| n_wdata | input | 8 | Narrow port write byte |
| n_rdata | output | 8 | Narrow port read byte, one cycle after the access |
| w_en | input | 1 | Wide port access enable |
| w_we | input | 1 | Wide port write strobe, acted on only with `w_en` |
| w_addr | input | 9 | Wide port word address |
| w_wdata | input | 32 | Wide port write word |
| w_rdata | output | 32 | Wide port read word, one cycle after the access |

## Verification
A wrong lane decode or a swapped byte order shows up on the first cross-port read after a write. One cycle after that read, the word carries bytes in the wrong lanes, or the narrow port returns a neighbouring byte. A wrong read-first choice or an enable leaking into the read register changes `n_rdata` or `w_rdata` on the very cycle after the offending edge. The hold checks flag that at once. A bad partition force shows as aliasing that is absent, or as a narrow write that leaks into a wide-port word. That leak is visible on the next wide read of that word.

// File: rtl/apram_pkg.sv
package apram_pkg;

  // Value a partition force drives onto the selected address bit.
  typedef enum logic [0:0] {
    FORCE_LOW  = 1'b0,
    FORCE_HIGH = 1'b1
  } force_e;

  localparam int unsigned APRAM_NARROW_W_DEF = 8;
  localparam int unsigned APRAM_WIDE_W_DEF   = 32;
  localparam int unsigned APRAM_BYTES_DEF    = 2048;

endpackage

// File: rtl/apram_addr_map.sv
module apram_addr_map
  import apram_pkg::*;
#(
  parameter int     AW      = 11,
  parameter bit     PART_EN = 1'b0,
  parameter int     BIT_IDX = 10,
  parameter force_e FORCE   = FORCE_LOW
) (
  input  logic [AW-1:0] addr_in,
  output logic [AW-1:0] addr_out
);

  generate
    if (PART_EN) begin : g_part
      always_comb begin
        addr_out          = addr_in;
        addr_out[BIT_IDX] = FORCE;
      end
    end else begin : g_flat
      assign addr_out = addr_in;
    end
  endgenerate

endmodule

// File: rtl/apram_byte_bank.sv
module apram_byte_bank #(
  parameter int DW   = 8,
  parameter int ROWS = 512,
  localparam int RW  = $clog2(ROWS)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          n_en,
  input  logic          n_we,
  input  logic [RW-1:0] n_row,
  input  logic [DW-1:0] n_wd,
  output logic [DW-1:0] n_rd,
  input  logic          w_en,
  input  logic          w_we,
  input  logic [RW-1:0] w_row,
  input  logic [DW-1:0] w_wd,
  output logic [DW-1:0] w_rd
);

  logic [DW-1:0] mem [ROWS];
  logic [DW-1:0] n_rd_d, n_rd_q;
  logic [DW-1:0] w_rd_d, w_rd_q;

  // Storage: narrow write first, wide write second; a same-row clash is
  // outside the contract, the later assignment simply lands.
  always_ff @(posedge clk) begin
    if (n_en && n_we) begin
      mem[n_row] <= n_wd;
    end
    if (w_en && w_we) begin
      mem[w_row] <= w_wd;
    end
  end

  // Read-first: the read register samples the array before this edge's write.
  always_comb begin
    n_rd_d = n_rd_q;
    if (n_en) begin
      n_rd_d = mem[n_row];
    end
  end

  always_comb begin
    w_rd_d = w_rd_q;
    if (w_en) begin
      w_rd_d = mem[w_row];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      n_rd_q <= '0;
      w_rd_q <= '0;
    end else begin
      n_rd_q <= n_rd_d;
      w_rd_q <= w_rd_d;
    end
  end

  assign n_rd = n_rd_q;
  assign w_rd = w_rd_q;

endmodule

// File: rtl/apram_lane_mux.sv
module apram_lane_mux #(
  parameter int DW    = 8,
  parameter int RATIO = 4,
  localparam int LW   = $clog2(RATIO)
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       en,
  input  logic [LW-1:0]              lane_in,
  input  logic [RATIO-1:0][DW-1:0]   rd_all,
  output logic [DW-1:0]              rd_out
);

  logic [LW-1:0] lane_d, lane_q;

  always_comb begin
    lane_d = lane_q;
    if (en) begin
      lane_d = lane_in;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lane_q <= '0;
    end else begin
      lane_q <= lane_d;
    end
  end

  assign rd_out = rd_all[lane_q];

endmodule

// File: rtl/asym_dpram.sv
module asym_dpram
  import apram_pkg::*;
#(
  parameter int NARROW_W = APRAM_NARROW_W_DEF,
  parameter int WIDE_W   = APRAM_WIDE_W_DEF,
  parameter int BYTES    = APRAM_BYTES_DEF,
  parameter bit PART_EN  = 1'b0,
  parameter int PART_BIT = 10
) (
  input  logic                                              clk,
  input  logic                                              rst_n,
  input  logic                                              n_en,
  input  logic                                              n_we,
  input  logic [$clog2(BYTES)-1:0]                          n_addr,
  input  logic [NARROW_W-1:0]                               n_wdata,
  output logic [NARROW_W-1:0]                               n_rdata,
  input  logic                                              w_en,
  input  logic                                              w_we,
  input  logic [$clog2(BYTES)-$clog2(WIDE_W/NARROW_W)-1:0]  w_addr,
  input  logic [WIDE_W-1:0]                                 w_wdata,
  output logic [WIDE_W-1:0]                                 w_rdata
);

  localparam int RATIO  = WIDE_W / NARROW_W;
  localparam int LANE_W = $clog2(RATIO);
  localparam int NA_W   = $clog2(BYTES);
  localparam int WA_W   = NA_W - LANE_W;
  localparam int ROWS   = BYTES / RATIO;

  // Reset: asserted asynchronously, released through two flops.
  logic [1:0] rst_pipe_d, rst_pipe_q;
  logic       rst_q;

  always_comb begin
    rst_pipe_d = {rst_pipe_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_pipe_q <= '0;
    end else begin
      rst_pipe_q <= rst_pipe_d;
    end
  end

  assign rst_q = rst_pipe_q[1];

  // Address mapping with optional partition force.
  logic [NA_W-1:0]   n_phys;
  logic [WA_W-1:0]   w_phys;
  logic [WA_W-1:0]   n_row;
  logic [LANE_W-1:0] n_lane;

  apram_addr_map #(
    .AW      (NA_W),
    .PART_EN (PART_EN),
    .BIT_IDX (PART_BIT),
    .FORCE   (FORCE_LOW)
  ) u_map_n (
    .addr_in  (n_addr),
    .addr_out (n_phys)
  );

  apram_addr_map #(
    .AW      (WA_W),
    .PART_EN (PART_EN),
    .BIT_IDX (PART_BIT - LANE_W),
    .FORCE   (FORCE_HIGH)
  ) u_map_w (
    .addr_in  (w_addr),
    .addr_out (w_phys)
  );

  assign n_row  = n_phys[NA_W-1:LANE_W];
  assign n_lane = n_phys[LANE_W-1:0];

  // One byte-wide bank per wide lane.
  logic [RATIO-1:0][NARROW_W-1:0] bank_n_rd;

  for (genvar g = 0; g < RATIO; g++) begin : g_bank
    logic lane_hit;
    assign lane_hit = (n_lane == LANE_W'(g));

    apram_byte_bank #(
      .DW   (NARROW_W),
      .ROWS (ROWS)
    ) u_bank (
      .clk   (clk),
      .rst_n (rst_q),
      .n_en  (n_en),
      .n_we  (n_we && lane_hit),
      .n_row (n_row),
      .n_wd  (n_wdata),
      .n_rd  (bank_n_rd[g]),
      .w_en  (w_en),
      .w_we  (w_we),
      .w_row (w_phys),
      .w_wd  (w_wdata[g*NARROW_W +: NARROW_W]),
      .w_rd  (w_rdata[g*NARROW_W +: NARROW_W])
    );
  end

  apram_lane_mux #(
    .DW    (NARROW_W),
    .RATIO (RATIO)
  ) u_lane_mux (
    .clk     (clk),
    .rst_n   (rst_q),
    .en      (n_en),
    .lane_in (n_lane),
    .rd_all  (bank_n_rd),
    .rd_out  (n_rdata)
  );

  // Reset release leaves both read outputs at zero.
  assert_rdata_zero_R1: assert property (@(posedge clk)
    $rose(rst_q) |-> (n_rdata == '0 && w_rdata == '0));

  // An idle port keeps its read output.
  assert_narrow_hold_R6: assert property (@(posedge clk) disable iff (!rst_q)
    !n_en |=> $stable(n_rdata));

  assert_wide_hold_R6: assert property (@(posedge clk) disable iff (!rst_q)
    !w_en |=> $stable(w_rdata));

  if (PART_EN) begin : g_part_chk
    // Narrow port confined to the half with the selected bit low.
    assert_part_narrow_R8: assert property (@(posedge clk) disable iff (!rst_q)
      n_en |-> (n_row[PART_BIT-LANE_W] == 1'b0));

    // Wide port confined to the half with the selected bit high.
    assert_part_wide_R8: assert property (@(posedge clk) disable iff (!rst_q)
      w_en |-> (w_phys[PART_BIT-LANE_W] == 1'b1));
  end

endmodule

// File: tb/asym_dpram_tb_top.sv
module asym_dpram_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  // Flat instance signals
  logic        n_en = 0, n_we = 0, w_en = 0, w_we = 0;
  logic [10:0] n_addr = '0;
  logic [7:0]  n_wdata = '0, n_rdata;
  logic [8:0]  w_addr = '0;
  logic [31:0] w_wdata = '0, w_rdata;

  // Partitioned instance signals
  logic        pn_en = 0, pn_we = 0, pw_en = 0, pw_we = 0;
  logic [10:0] pn_addr = '0;
  logic [7:0]  pn_wdata = '0, pn_rdata;
  logic [8:0]  pw_addr = '0;
  logic [31:0] pw_wdata = '0, pw_rdata;

  asym_dpram dut_i (
    .clk(clk), .rst_n(rst_n),
    .n_en(n_en), .n_we(n_we), .n_addr(n_addr), .n_wdata(n_wdata), .n_rdata(n_rdata),
    .w_en(w_en), .w_we(w_we), .w_addr(w_addr), .w_wdata(w_wdata), .w_rdata(w_rdata)
  );

  asym_dpram #(.PART_EN(1'b1), .PART_BIT(10)) dut_p_i (
    .clk(clk), .rst_n(rst_n),
    .n_en(pn_en), .n_we(pn_we), .n_addr(pn_addr), .n_wdata(pn_wdata), .n_rdata(pn_rdata),
    .w_en(pw_en), .w_we(pw_we), .w_addr(pw_addr), .w_wdata(pw_wdata), .w_rdata(pw_rdata)
  );

  logic [7:0] mem_m [2048];

  function automatic logic [31:0] wfun(input int i);
    return {8'(i*3+1), 8'(i*5+2), 8'(i*7+3), 8'(i*11+4)};
  endfunction

  function automatic logic [31:0] mword(input int w);
    return {mem_m[w*4+3], mem_m[w*4+2], mem_m[w*4+1], mem_m[w*4]};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic n_op(input bit p, input bit we, input logic [10:0] a,
                      input logic [7:0] d, output logic [7:0] r);
    @(negedge clk);
    if (p) begin pn_en = 1; pn_we = we; pn_addr = a; pn_wdata = d; end
    else   begin n_en  = 1; n_we  = we; n_addr  = a; n_wdata  = d; end
    @(negedge clk);
    n_en = 0; n_we = 0; pn_en = 0; pn_we = 0;
    r = p ? pn_rdata : n_rdata;
  endtask

  task automatic w_op(input bit p, input bit we, input logic [8:0] a,
                      input logic [31:0] d, output logic [31:0] r);
    @(negedge clk);
    if (p) begin pw_en = 1; pw_we = we; pw_addr = a; pw_wdata = d; end
    else   begin w_en  = 1; w_we  = we; w_addr  = a; w_wdata  = d; end
    @(negedge clk);
    w_en = 0; w_we = 0; pw_en = 0; pw_we = 0;
    r = p ? pw_rdata : w_rdata;
  endtask

  task automatic t_reset();
    chk("R1 narrow reset", 32'(n_rdata), 32'h0);
    chk("R1 wide reset", w_rdata, 32'h0);
    chk("R1 part wide reset", pw_rdata, 32'h0);
  endtask

  task automatic t_fill();
    logic [31:0] r;
    for (int i = 0; i < 512; i++) begin
      w_op(0, 1, 9'(i), wfun(i), r);
      for (int k = 0; k < 4; k++) mem_m[i*4+k] = wfun(i)[k*8 +: 8];
    end
    w_op(0, 0, 9'd300, 32'h0, r);
    chk("R3 wide read after fill", r, mword(300));
  endtask

  task automatic t_narrow_rw();
    logic [7:0] r;
    n_op(0, 1, 11'h123, 8'h5A, r);
    chk("R5 narrow read-first", 32'(r), 32'(mem_m[11'h123]));
    mem_m[11'h123] = 8'h5A;
    n_op(0, 0, 11'h123, 8'h00, r);
    chk("R2 narrow readback", 32'(r), 32'h5A);
    n_op(0, 0, 11'h7FF, 8'h00, r);
    chk("R2 narrow top byte", 32'(r), 32'(mem_m[2047]));
  endtask

  task automatic t_wide_rw();
    logic [31:0] r;
    w_op(0, 1, 9'h040, 32'hCAFE_F00D, r);
    chk("R5 wide read-first", r, mword(9'h040));
    for (int k = 0; k < 4; k++) mem_m[9'h040*4+k] = 32'hCAFE_F00D >> (8*k);
    w_op(0, 0, 9'h040, 32'h0, r);
    chk("R3 wide readback", r, 32'hCAFE_F00D);
  endtask

  task automatic t_mapping();
    logic [7:0]  rn;
    logic [31:0] rw;
    for (int k = 0; k < 4; k++) begin
      n_op(0, 1, 11'(11'h200 + k), 8'(8'h11 * (k+1)), rn);
      mem_m[11'h200 + k] = 8'(8'h11 * (k+1));
    end
    w_op(0, 0, 9'h080, 32'h0, rw);
    chk("R4 bytes to word", rw, 32'h4433_2211);
    w_op(0, 1, 9'h081, 32'hDDCC_BBAA, rw);
    for (int k = 0; k < 4; k++) mem_m[9'h081*4+k] = 32'hDDCC_BBAA >> (8*k);
    n_op(0, 0, 11'h205, 8'h0, rn);
    chk("R4 word lane1 to byte", 32'(rn), 32'hBB);
    n_op(0, 0, 11'h207, 8'h0, rn);
    chk("R4 word lane3 to byte", 32'(rn), 32'hDD);
  endtask

  task automatic t_idle_hold();
    logic [7:0]  rn;
    logic [31:0] rw, hold_w;
    logic [7:0]  hold_n;
    n_op(0, 0, 11'h123, 8'h0, rn);
    w_op(0, 0, 9'h040, 32'h0, rw);
    hold_n = n_rdata; hold_w = w_rdata;
    for (int c = 0; c < 3; c++) begin
      @(negedge clk);
      n_we = 1; n_addr = 11'(11'h077 + c); n_wdata = 8'hFF;
      w_we = 1; w_addr = 9'(9'h1A0 + c); w_wdata = 32'hFFFF_FFFF;
    end
    @(negedge clk);
    chk("R6 narrow holds while idle", 32'(n_rdata), 32'(hold_n));
    chk("R6 wide holds while idle", w_rdata, hold_w);
    n_we = 0; w_we = 0;
    n_op(0, 0, 11'h078, 8'h0, rn);
    chk("R6 idle narrow wrote nothing", 32'(rn), 32'(mem_m[11'h078]));
    w_op(0, 0, 9'h1A1, 32'h0, rw);
    chk("R6 idle wide wrote nothing", rw, mword(9'h1A1));
  endtask

  task automatic t_dual_write();
    logic [7:0]  rn;
    logic [31:0] rw;
    @(negedge clk);
    n_en = 1; n_we = 1; n_addr = 11'h010; n_wdata = 8'h3C;
    w_en = 1; w_we = 1; w_addr = 9'h1F0; w_wdata = 32'h1234_5678;
    @(negedge clk);
    n_en = 0; n_we = 0; w_en = 0; w_we = 0;
    mem_m[11'h010] = 8'h3C;
    for (int k = 0; k < 4; k++) mem_m[9'h1F0*4+k] = 32'h1234_5678 >> (8*k);
    w_op(0, 0, 9'h004, 32'h0, rw);
    chk("R7 narrow write seen by wide", rw, mword(4));
    n_op(0, 0, 11'h7C2, 8'h0, rn);
    chk("R7 wide write seen by narrow", 32'(rn), 32'h34);
  endtask

  task automatic t_partition();
    logic [7:0]  rn;
    logic [31:0] rw;
    n_op(1, 1, 11'h004, 8'h11, rn);
    w_op(1, 1, 9'h001, 32'hA1B2_C3D4, rw);
    n_op(1, 0, 11'h404, 8'h0, rn);
    chk("R8 narrow upper aliases lower", 32'(rn), 32'h11);
    n_op(1, 1, 11'h405, 8'hAA, rn);
    w_op(1, 0, 9'h001, 32'h0, rw);
    chk("R8 narrow write absent from wide half", rw, 32'hA1B2_C3D4);
    n_op(1, 0, 11'h005, 8'h0, rn);
    chk("R8 narrow alias readback", 32'(rn), 32'hAA);
    w_op(1, 0, 9'h101, 32'h0, rw);
    chk("R8 wide upper aliases", rw, 32'hA1B2_C3D4);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    repeat (3) @(negedge clk);
    t_fill();
    t_narrow_rw();
    t_wide_rw();
    t_mapping();
    t_idle_hold();
    t_dual_write();
    t_partition();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule